// File: doc/BRIEF.md
# SPI Master Transfer Engine

A master-only serial engine that moves 8-bit frames out on MOSI and in from MISO, most significant bit first. Software sets it up through a small word-wide register port. It programs the clock divider, the clock polarity and phase, and the transmit byte. It also programs a 32-bit frame count and a one-hot target select. It then starts a transfer by writing the control word with the enable and master bits set.

While a transfer runs, the status word reports it as active. The engine sends the transmit byte once per frame and stores the most recently received byte in the data register. After the programmed number of frames it stops and emits a one-cycle done pulse. A soft-reset bit in the control word, or a control write that clears enable, abandons a transfer at once and does not raise done.

The SCLK generator has two divide formulas, chosen per transfer by a clock-mode bit. The select lines are active low. They are the one-hot target field gated by a global output-enable bit.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, all select lines are high, SCLK and done are low, and the status word reads zero.
- R2: A control write (address 0) starts a transfer only when all of the following hold: the engine is idle, bit 0 (enable) is set, bit 1 (master) is set, bit 31 is clear, and the frame count is nonzero. Status (address 5) bit 14 is set while the transfer runs.
- R3: With control bit 28 set, one SCLK period lasts 2*(N+1) system clocks. N is the 8-bit divider at address 3.
- R4: With control bit 28 clear, only divider bits 3..0 count and the period is 2N+1 system clocks. A value of 0 behaves as 1, giving a period of 3.
- R5: Each frame shifts the transmit byte (written at address 4) out on MOSI MSB first. The byte sampled from MISO, MSB first, reads back at address 4 once the frame ends.
- R6: SCLK idles at the level of control bit 24. With control bit 25 clear, data is sampled on the first SCLK edge of each bit; with it set, on the second edge.
- R7: The frame count is 32 bits: control bits 23..8 form the low half and address 1 holds the high half. Exactly that many frames are sent, and a count of zero starts nothing.
- R8: When the last frame completes, done_o pulses high for exactly one cycle and the active flag drops on the same edge.
- R9: A write to address 2 takes a target index in bits 3..0. Index 0..7 sets that single bit of the 8-bit select field, and any other index clears the field. The field reads back in bits 7..0.
- R10: Select bit 9 is the output gate: ss_no equals the inverse of the select field while the gate is set, and is all ones while it is clear.
- R11: While control bit 31 is set, the engine is held idle. A control write that sets bit 31 or clears enable aborts a running transfer without a done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| miso_i | input | 1 | Serial data from the target |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the target |
| ss_no | output | 8 | Target selects, active low |
| done_o | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The hardest situation to reach from the ports is the effect of the upper half of the frame count. Running 65536 frames is too long for a bench. The stimulus therefore loads only the high count register, leaving the low half zero, and observes that a transfer starts and stays active. It then aborts that transfer through the control word and confirms that no done pulse appears. A bench-side target model drives MISO from the SCLK edges it observes, so received bytes and the SCLK period are checked under every polarity, phase and divider formula.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNTHI = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;

  localparam int unsigned C_EN      = 0;
  localparam int unsigned C_MST     = 1;
  localparam int unsigned C_CNT_LO  = 8;
  localparam int unsigned C_CPOL    = 24;
  localparam int unsigned C_CPHA    = 25;
  localparam int unsigned C_CLKMODE = 28;
  localparam int unsigned C_SRST    = 31;

  localparam int unsigned S_ACT     = 14;
  localparam int unsigned SEL_GATE  = 9;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SLOW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             half_i,
  input  logic             mode_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             end_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     len;
  logic [SLOW_W-1:0] n_s;
  logic [CW-1:0]     n_ext;

  // mode 1: both halves N+1; mode 0: N+1 then N, N floored at 1
  always_comb begin
    n_s = div_i[SLOW_W-1:0];
    if (n_s == '0) n_s = SLOW_W'(1);
    n_ext = {{(CW-SLOW_W){1'b0}}, n_s};
    if (mode_i) len = {1'b0, div_i} + CW'(1);
    else        len = half_i ? n_ext : n_ext + CW'(1);
  end

  assign end_o = run_i && (cnt_q == len - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || end_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_data_i,
  input  logic               shift_i,
  input  logic               sample_i,
  input  logic               miso_i,
  output logic               mosi_o,
  output logic [FRAME_W-1:0] rx_o
);
  logic [FRAME_W-1:0] tx_sh_q, rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      if (load_i)       tx_sh_q <= load_data_i;
      else if (shift_i) tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
      if (sample_i)     rx_sh_q <= {rx_sh_q[FRAME_W-2:0], miso_i};
    end
  end

  assign mosi_o = tx_sh_q[FRAME_W-1];
  assign rx_o   = rx_sh_q;
endmodule

// File: rtl/spi_sel_unit.sv
module spi_sel_unit #(
  parameter int unsigned NSEL  = 8,
  parameter int unsigned IDX_W = $clog2(NSEL) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             gate_i,
  output logic [NSEL-1:0]  field_o,
  output logic             gate_o,
  output logic [NSEL-1:0]  ss_no
);
  logic [NSEL-1:0] field_d, field_q;
  logic            gate_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_dec
    assign field_d[i] = (idx_i == IDX_W'(i));
    assign ss_no[i]   = ~(field_q[i] & gate_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      gate_q  <= 1'b0;
    end else if (we_i) begin
      field_q <= field_d;
      gate_q  <= gate_i;
    end
  end

  assign field_o = field_q;
  assign gate_o  = gate_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned NSEL    = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned CNT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NSEL-1:0]   ss_no,
  output logic              done_o
);
  localparam int unsigned HALF_W = CNT_W / 2;
  localparam int unsigned BIT_W  = $clog2(FRAME_W);
  localparam int unsigned IDX_W  = $clog2(NSEL) + 1;

  logic [31:0]        ctrl_q;
  logic [HALF_W-1:0]  cnt_hi_q;
  logic [DIV_W-1:0]   div_q;
  logic [FRAME_W-1:0] tx_q, rx_q, rx_word;
  logic               busy_q, half_q, done_q;
  logic [BIT_W-1:0]   bit_q;
  logic [CNT_W-1:0]   frm_q, total, total_wr;
  logic               half_end, last_bit, last_frame, frame_end;
  logic               wr_ctrl, start, abort, soft_rst, sh_mosi;
  logic [NSEL-1:0]    sel_field;
  logic               sel_gate;

  assign wr_ctrl    = we_i && (addr_i == A_CTRL);
  assign soft_rst   = ctrl_q[C_SRST];
  assign total      = {cnt_hi_q, ctrl_q[C_CNT_LO +: HALF_W]};
  assign total_wr   = {cnt_hi_q, wdata_i[C_CNT_LO +: HALF_W]};
  assign start      = wr_ctrl && !busy_q && wdata_i[C_EN] && wdata_i[C_MST]
                      && !wdata_i[C_SRST] && (total_wr != '0);
  assign abort      = busy_q && (soft_rst || (wr_ctrl && (!wdata_i[C_EN]
                      || !wdata_i[C_MST] || wdata_i[C_SRST])));
  assign last_bit   = (bit_q == BIT_W'(FRAME_W - 1));
  assign last_frame = (frm_q == total - CNT_W'(1));
  assign frame_end  = busy_q && half_end && half_q && last_bit;

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      cnt_hi_q <= '0;
      div_q    <= '0;
      tx_q     <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL:  ctrl_q   <= wdata_i;
        A_CNTHI: cnt_hi_q <= wdata_i[HALF_W-1:0];
        A_DIV:   div_q    <= wdata_i[DIV_W-1:0];
        A_DATA:  tx_q     <= wdata_i[FRAME_W-1:0];
        default: ;
      endcase
    end
  end

  // transfer sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= '0;
      frm_q  <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
      end else if (start) begin
        busy_q <= 1'b1;
        half_q <= 1'b0;
        bit_q  <= '0;
        frm_q  <= '0;
      end else if (busy_q && half_end) begin
        half_q <= ~half_q;
        if (half_q) begin
          bit_q <= last_bit ? '0 : bit_q + BIT_W'(1);
          if (last_bit) begin
            rx_q  <= rx_word;
            frm_q <= frm_q + CNT_W'(1);
            if (last_frame) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  spi_half_timer #(.DIV_W(DIV_W), .SLOW_W(4)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .half_i (half_q),
    .mode_i (ctrl_q[C_CLKMODE]),
    .div_i  (div_q),
    .end_o  (half_end)
  );

  spi_shift_unit #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start || (frame_end && !last_frame)),
    .load_data_i (tx_q),
    .shift_i     (busy_q && half_end && half_q && !last_bit),
    .sample_i    (busy_q && half_end && !half_q),
    .miso_i      (miso_i),
    .mosi_o      (sh_mosi),
    .rx_o        (rx_word)
  );

  spi_sel_unit #(.NSEL(NSEL), .IDX_W(IDX_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i && (addr_i == A_SEL)),
    .idx_i   (wdata_i[IDX_W-1:0]),
    .gate_i  (wdata_i[SEL_GATE]),
    .field_o (sel_field),
    .gate_o  (sel_gate),
    .ss_no   (ss_no)
  );

  // half 0 is the pre-sample half; phase flips which level it shows
  assign sclk_o = ctrl_q[C_CPOL] ^ (busy_q & (half_q ^ ctrl_q[C_CPHA]));
  assign mosi_o = busy_q & sh_mosi;
  assign done_o = done_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_CNTHI: rdata_o[HALF_W-1:0] = cnt_hi_q;
      A_SEL: begin
        rdata_o[NSEL-1:0] = sel_field;
        rdata_o[SEL_GATE] = sel_gate;
      end
      A_DIV:   rdata_o[DIV_W-1:0] = div_q;
      A_DATA:  rdata_o[FRAME_W-1:0] = rx_q;
      A_STAT:  rdata_o[S_ACT] = busy_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int unsigned NSEL = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic            busy_i,
  input logic            done_i,
  input logic            sclk_i,
  input logic            soft_rst_i,
  input logic            half_end_i,
  input logic            gate_i,
  input logic [NSEL-1:0] ss_ni
);
  p_ss_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |-> (ss_ni == '1));

  p_ss_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ss_ni));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_i && $past(busy_i)));

  p_soft_rst_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |-> !busy_i);

  p_sclk_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !half_end_i && !we_i) |=> $stable(sclk_i));
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.NSEL(NSEL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .busy_i     (busy_q),
  .done_i     (done_o),
  .sclk_i     (sclk_o),
  .soft_rst_i (soft_rst),
  .half_end_i (half_end),
  .gate_i     (sel_gate),
  .ss_ni      (ss_no)
);

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/100ps
module spi_xfer_engine_tb_top;
  import spi_eng_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        miso, sclk, mosi, done;
  logic [7:0]  ss_n;

  int total = 0, bad = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit done_prev = 1'b0;

  // target model / monitor state
  logic [7:0] sbyte = '0;
  int   sidx = 0;
  bit   mon_on = 1'b0;
  logic smp_lvl = 1'b1;
  int   mbit = 0;
  logic [7:0] mbyte = '0;
  int   frames = 0;
  int   exp_per = 0;
  int   t_prev = 0;
  logic [7:0] q_tx[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign miso = sbyte[7 - sidx];

  spi_xfer_engine dut_i (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .we_i (we),
    .wdata_i (wdata), .rdata_o (rdata), .miso_i (miso), .sclk_o (sclk),
    .mosi_o (mosi), .ss_no (ss_n), .done_o (done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] cw(input bit en, input bit mst, input bit pol, input bit pha,
                                     input bit mode, input bit srst, input logic [15:0] lo);
    cw = '0;
    cw[C_EN] = en; cw[C_MST] = mst; cw[C_CPOL] = pol; cw[C_CPHA] = pha;
    cw[C_CLKMODE] = mode; cw[C_SRST] = srst; cw[C_CNT_LO +: 16] = lo;
  endfunction

  // done monitor: pulse must be one cycle wide (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_prev) done_cnt++;
      if (done && done_prev) chk(1'b0, "R8 done width", 32'd2, 32'd1);
    end
    done_prev = done;
  end

  // scoreboard monitor at each sampling edge
  always @(sclk) begin
    if (mon_on && sclk == smp_lvl) begin
      mbyte = {mbyte[6:0], mosi};
      #1;
      sidx = (sidx + 1) % 8;
      if (mbit == 0) t_prev = cyc;
      if (mbit == 1) chk((cyc - t_prev) == exp_per, "R3/R4 period", cyc - t_prev, exp_per);
      mbit++;
      if (mbit == 8) begin
        mbit = 0;
        frames++;
        if (q_tx.size() == 0) chk(1'b0, "R5 unexpected frame", mbyte, 0);
        else begin
          logic [7:0] e;
          e = q_tx.pop_front();
          chk(mbyte == e, "R5 mosi byte", mbyte, e);
        end
      end
    end
  end

  task automatic run_xfer(input bit pol, input bit pha, input bit mode, input logic [7:0] dv,
                          input int n, input logic [7:0] txb, input logic [7:0] sb);
    logic [31:0] r;
    int d0, w;
    wr(A_DIV, {24'd0, dv});
    wr(A_DATA, {24'd0, txb});
    wr(A_CTRL, cw(0, 1, pol, pha, mode, 0, 16'(n)));
    chk(sclk == pol, "R6 idle level", sclk, pol);
    sbyte = sb; sidx = 0; mbit = 0; frames = 0;
    smp_lvl = ~(pol ^ pha);
    exp_per = mode ? 2 * (dv + 1) : ((dv[3:0] == 0) ? 3 : 2 * dv[3:0] + 1);
    for (int i = 0; i < n; i++) q_tx.push_back(txb);
    mon_on = 1'b1;
    d0 = done_cnt;
    wr(A_CTRL, cw(1, 1, pol, pha, mode, 0, 16'(n)));
    rd(A_STAT, r);
    chk(r[S_ACT] == 1'b1, "R2 active", r, 32'h4000);
    w = 0;
    while (done_cnt == d0 && w < 20000) begin @(negedge clk); w++; end
    chk(done_cnt == d0 + 1, "R8 done seen", done_cnt - d0, 1);
    @(negedge clk); @(negedge clk);
    mon_on = 1'b0;
    rd(A_STAT, r);
    chk(r[S_ACT] == 1'b0, "R8 inactive", r, 0);
    rd(A_DATA, r);
    chk(r[7:0] == sb, "R5 rx byte", r, sb);
    chk(frames == n, "R7 frame count", frames, n);
    chk(q_tx.size() == 0, "R7 all frames sent", q_tx.size(), 0);
    chk(sclk == pol, "R6 idle after", sclk, pol);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(ss_n == 8'hFF, "R1 ss", ss_n, 8'hFF);
    chk(sclk == 1'b0 && done == 1'b0, "R1 sclk/done", {sclk, done}, 0);
    rd(A_STAT, r);
    chk(r == 0, "R1 status", r, 0);

    // R9 / R10
    wr(A_SEL, 32'h3);
    rd(A_SEL, r);
    chk(r == 32'h08, "R9 onehot", r, 32'h08);
    chk(ss_n == 8'hFF, "R10 gate off", ss_n, 8'hFF);
    wr(A_SEL, 32'h200 | 32'h6);
    rd(A_SEL, r);
    chk(r == 32'h240, "R9 readback", r, 32'h240);
    chk(ss_n == 8'hBF, "R10 gate on", ss_n, 8'hBF);
    wr(A_SEL, 32'h200 | 32'h9);
    rd(A_SEL, r);
    chk(r == 32'h200, "R9 out of range", r, 32'h200);
    chk(ss_n == 8'hFF, "R10 empty field", ss_n, 8'hFF);
    wr(A_SEL, 32'h200);

    // transfers across modes
    run_xfer(0, 0, 1, 8'd2,    1, 8'hA5, 8'h3C);  // R3 R5 R6
    run_xfer(1, 1, 1, 8'd0,    3, 8'h81, 8'hC3);  // R6 R7
    run_xfer(0, 1, 0, 8'd4,    2, 8'h5A, 8'h96);  // R4 period 9
    run_xfer(1, 0, 0, 8'h20,   1, 8'h7E, 8'h01);  // R4 N=0 -> 3

    // R7 zero count starts nothing
    d0 = done_cnt;
    wr(A_CTRL, cw(1, 1, 0, 0, 1, 0, 16'd0));
    repeat (5) @(negedge clk);
    rd(A_STAT, r);
    chk(r[S_ACT] == 1'b0, "R7 zero count", r, 0);

    // R7 high half alone starts a transfer; R11 abort by clearing enable
    wr(A_CNTHI, 32'h1);
    rd(A_CNTHI, r);
    chk(r == 32'h1, "R7 high half readback", r, 1);
    wr(A_CTRL, cw(0, 1, 0, 0, 1, 0, 16'd0));
    wr(A_CTRL, cw(1, 1, 0, 0, 1, 0, 16'd0));
    repeat (20) @(negedge clk);
    rd(A_STAT, r);
    chk(r[S_ACT] == 1'b1, "R7 high half active", r, 32'h4000);
    wr(A_CTRL, cw(0, 1, 0, 0, 1, 0, 16'd0));
    rd(A_STAT, r);
    chk(r[S_ACT] == 1'b0, "R11 enable abort", r, 0);

    // R11 soft reset aborts; master clear does not start
    wr(A_CTRL, cw(1, 1, 0, 0, 1, 0, 16'd0));
    repeat (10) @(negedge clk);
    wr(A_CTRL, cw(1, 1, 0, 0, 1, 1, 16'd0));
    rd(A_STAT, r);
    chk(r[S_ACT] == 1'b0, "R11 soft reset abort", r, 0);
    wr(A_CTRL, cw(0, 1, 0, 0, 1, 0, 16'd0));
    wr(A_CTRL, cw(1, 0, 0, 0, 1, 0, 16'd0));
    repeat (5) @(negedge clk);
    rd(A_STAT, r);
    chk(r[S_ACT] == 1'b0, "R2 master clear no start", r, 0);
    repeat (5) @(negedge clk);
    chk(done_cnt == d0, "R11 no done on abort", done_cnt - d0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule